// File: doc/BRIEF.md
# Programmable Raster Timing Generator

This block produces the raster timing of a display from two position counters that run on the pixel clock. A horizontal counter steps once per cycle and wraps at a programmable last column. A vertical counter steps each time the horizontal counter wraps and wraps at a programmable last line. Eight timing outputs are derived from these counters: horizontal and vertical sync, horizontal and vertical blank, horizontal and vertical pixel enable, and a horizontal and a vertical colour-map update window. Each output has its own pair of software-written positions. It rises when its counter reaches the start position and falls when the counter reaches the stop position. A window whose start lies beyond its stop wraps around the end of the line or frame.

Software drives the block through a single-cycle write strobe with an address and write data, and reads any register combinationally on the read data port. A control register can freeze both counters, or restart them from the origin. A raster whose totals are zero does not move. Compare positions written while the raster runs are held back until the next frame begins, so a frame never mixes two settings. A scan-out enable bit is copied into a read-only status bit only at the frame boundary. Software polls that copy to learn when a change has reached the hardware.

Top module: `raster_timing_gen`

## Requirements
- R1: With a nonzero totals register and the freeze bit clear, the horizontal counter advances by one each cycle and returns to 0 on the cycle after it is at or beyond max X. The vertical counter advances only on that horizontal wrap and returns to 0 past max Y. Address 1 reads the horizontal counter in bits 11:0, the vertical counter in bits 27:16 and the freeze flag in bit 31.
- R2: The totals register sits at address 1's neighbour, address 0, with max X in bits 11:0 and max Y in bits 27:16. It reads back as written. While it holds zero both counters keep their values.
- R3: A write to address 1 with bit 31 set stops both counters where they are. A write to address 1 with bit 31 clear releases the freeze and puts both counters at 0 on the following cycle.
- R4: Addresses 2 to 9 hold, in this order, the compare pairs for hsync, vsync, hblank, vblank, horizontal pixel enable, vertical pixel enable, horizontal colour-map window and vertical colour-map window. Each pair has its start in bits 11:0 and its stop in bits 27:16. The even-numbered outputs follow the horizontal counter and the odd-numbered ones follow the vertical counter. An output is high on every cycle its counter is at or after the start and before the stop.
- R5: When the start is greater than the stop, the output is high from the start through the counter wrap and falls at the stop.
- R6: When the start equals the stop, the output never goes high. This covers the value all ones, which places both positions beyond any used total. After reset every pair reads 0x0FFF0FFF.
- R7: A compare pair reads back its written value at once. While the raster runs, the new value drives the output from the first cycle of the next frame. While the raster is frozen or parked, it drives the output from the next cycle.
- R8: Bit 0 of address 10 is a writable scan-out enable. Bit 0 of address 11 is a read-only copy of it, refreshed only on the edge where the counters wrap from the last position of a frame to the origin.
- R9: After reset all timing outputs are low, both counters and the totals are zero, and both scan-out bits are clear. The outputs are registered and change on the same edge as the counters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_we | input | 1 | Register write strobe, one cycle per write |
| reg_addr | input | 4 | Register address for read and write |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Combinational read data for reg_addr |
| hsync | output | 1 | Horizontal sync |
| vsync | output | 1 | Vertical sync |
| hblank | output | 1 | Horizontal blank |
| vblank | output | 1 | Vertical blank |
| hpix_en | output | 1 | Horizontal pixel enable |
| vpix_en | output | 1 | Vertical pixel enable |
| hcmap_win | output | 1 | Horizontal colour-map update window |
| vcmap_win | output | 1 | Vertical colour-map update window |

## Verification
A wrong counter value shows up within one cycle: the position read back at address 1 no longer matches, and every horizontal output sits at the wrong column of its window. A bad active compare register, or one loaded at the wrong time, shows up within one frame, because the output edges move away from the columns and lines that were programmed. A missed or early shadow copy of the scan-out bit is seen by polling address 11 across the frame boundary. The bench keeps its own model of the counters, the pending and active compare pairs and the shadow bit. It compares all eight outputs on every cycle, and compares the read data on every cycle without a write.

// File: rtl/raster_pkg.sv
package raster_pkg;

  localparam int unsigned REG_AW     = 4;
  localparam int unsigned DATA_W     = 32;
  localparam int unsigned NUM_WIN    = 8;
  localparam int unsigned WIN_BASE   = 2;
  localparam int unsigned HI_LSB     = 16;
  localparam int unsigned FREEZE_BIT = 31;

  typedef enum logic [REG_AW-1:0] {
    SEL_TOTALS  = 4'd0,
    SEL_COUNT   = 4'd1,
    SEL_HSYNC   = 4'd2,
    SEL_VSYNC   = 4'd3,
    SEL_HBLANK  = 4'd4,
    SEL_VBLANK  = 4'd5,
    SEL_HPIX    = 4'd6,
    SEL_VPIX    = 4'd7,
    SEL_HCMAP   = 4'd8,
    SEL_VCMAP   = 4'd9,
    SEL_SCAN    = 4'd10,
    SEL_SCAN_HW = 4'd11
  } reg_sel_e;

  // window membership: start inclusive, stop exclusive, wrap when start > stop
  function automatic logic win_hit(input logic [15:0] pos,
                                   input logic [15:0] on_at,
                                   input logic [15:0] off_at);
    logic hit;
    if (on_at == off_at)     hit = 1'b0;
    else if (on_at < off_at) hit = (pos >= on_at) && (pos < off_at);
    else                     hit = (pos >= on_at) || (pos < off_at);
    return hit;
  endfunction

  // one counter step with wrap at or beyond the last position
  function automatic logic [15:0] step_pos(input logic [15:0] pos,
                                           input logic [15:0] last);
    return (pos >= last) ? 16'd0 : pos + 16'd1;
  endfunction

endpackage

// File: rtl/raster_counter.sv
module raster_counter
  import raster_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [CW-1:0] max_x,
  input  logic [CW-1:0] max_y,
  input  logic          parked,
  input  logic          frozen,
  input  logic          restart,
  output logic [CW-1:0] h_cnt,
  output logic [CW-1:0] v_cnt,
  output logic [CW-1:0] h_nxt,
  output logic [CW-1:0] v_nxt,
  output logic          frame_wrap
);

  logic advance;
  logic h_last;
  logic v_last;

  assign advance = !parked && !frozen;
  assign h_last  = (h_cnt >= max_x);
  assign v_last  = (v_cnt >= max_y);

  always_comb begin
    h_nxt = h_cnt;
    v_nxt = v_cnt;
    if (restart) begin
      h_nxt = '0;
      v_nxt = '0;
    end else if (advance) begin
      h_nxt = CW'(step_pos(16'(h_cnt), 16'(max_x)));
      if (h_last) v_nxt = CW'(step_pos(16'(v_cnt), 16'(max_y)));
    end
  end

  assign frame_wrap = advance && !restart && h_last && v_last;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      h_cnt <= '0;
      v_cnt <= '0;
    end else begin
      h_cnt <= h_nxt;
      v_cnt <= v_nxt;
    end
  end

  p_freeze_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    frozen && !restart |=> (h_cnt == $past(h_cnt)) && (v_cnt == $past(v_cnt)));

  p_restart_origin_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (h_cnt == '0) && (v_cnt == '0));

  p_line_wrap_r1: assert property (@(posedge clk) disable iff (!rst_n)
    advance && !restart && h_last |=> (h_cnt == '0));

  p_frame_origin_r1: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (h_cnt == '0) && (v_cnt == '0));

  p_park_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    parked && !restart |=> $stable(h_cnt) && $stable(v_cnt));

endmodule

// File: rtl/timing_window.sv
module timing_window
  import raster_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              we,
  input  logic [DATA_W-1:0] wdata,
  input  logic              load,
  input  logic [CW-1:0]     pos_nxt,
  output logic [DATA_W-1:0] rd_val,
  output logic              win_out
);

  logic [CW-1:0] pend_on, pend_off;
  logic [CW-1:0] act_on, act_off;
  logic [CW-1:0] on_sel, off_sel;

  assign on_sel  = load ? pend_on  : act_on;
  assign off_sel = load ? pend_off : act_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_on  <= '1;
      pend_off <= '1;
      act_on   <= '1;
      act_off  <= '1;
      win_out  <= 1'b0;
    end else begin
      if (load) begin
        act_on  <= pend_on;
        act_off <= pend_off;
      end
      if (we) begin
        pend_on  <= wdata[CW-1:0];
        pend_off <= wdata[HI_LSB +: CW];
      end
      win_out <= win_hit(16'(pos_nxt), 16'(on_sel), 16'(off_sel));
    end
  end

  always_comb begin
    rd_val = '0;
    rd_val[CW-1:0]       = pend_on;
    rd_val[HI_LSB +: CW] = pend_off;
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[HI_LSB-1:CW], wdata[DATA_W-1:HI_LSB+CW]};

  p_empty_low_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (act_on == act_off) |-> !win_out);

  p_hold_until_load_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> (act_on == $past(act_on)) && (act_off == $past(act_off)));

  p_readback_r7: assert property (@(posedge clk) disable iff (!rst_n)
    we |=> (rd_val[CW-1:0] == $past(wdata[CW-1:0])));

endmodule

// File: rtl/raster_regs.sv
module raster_regs
  import raster_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic                           clk,
  input  logic                           rst_n,
  input  logic                           we,
  input  logic [REG_AW-1:0]              addr,
  input  logic [DATA_W-1:0]              wdata,
  output logic [DATA_W-1:0]              rdata,
  input  logic                           frame_wrap,
  input  logic [CW-1:0]                  h_cnt,
  input  logic [CW-1:0]                  v_cnt,
  input  logic [NUM_WIN-1:0][DATA_W-1:0] win_rd,
  output logic [CW-1:0]                  max_x,
  output logic [CW-1:0]                  max_y,
  output logic                           parked,
  output logic                           frozen,
  output logic                           restart,
  output logic [NUM_WIN-1:0]             win_we
);

  reg_sel_e sel;
  logic     scan_en;
  logic     scan_hw;

  assign sel     = reg_sel_e'(addr);
  assign parked  = (max_x == '0) && (max_y == '0);
  assign restart = we && (sel == SEL_COUNT) && !wdata[FREEZE_BIT];

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_dec
    assign win_we[i] = we && (addr == REG_AW'(WIN_BASE + i));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      max_x   <= '0;
      max_y   <= '0;
      frozen  <= 1'b0;
      scan_en <= 1'b0;
      scan_hw <= 1'b0;
    end else begin
      if (frame_wrap) scan_hw <= scan_en;
      if (we) begin
        case (sel)
          SEL_TOTALS: begin
            max_x <= wdata[CW-1:0];
            max_y <= wdata[HI_LSB +: CW];
          end
          SEL_COUNT: frozen  <= wdata[FREEZE_BIT];
          SEL_SCAN:  scan_en <= wdata[0];
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    rdata = '0;
    case (sel)
      SEL_TOTALS: begin
        rdata[CW-1:0]       = max_x;
        rdata[HI_LSB +: CW] = max_y;
      end
      SEL_COUNT: begin
        rdata[CW-1:0]       = h_cnt;
        rdata[HI_LSB +: CW] = v_cnt;
        rdata[FREEZE_BIT]   = frozen;
      end
      SEL_HSYNC, SEL_VSYNC, SEL_HBLANK, SEL_VBLANK,
      SEL_HPIX, SEL_VPIX, SEL_HCMAP, SEL_VCMAP:
        rdata = win_rd[addr - REG_AW'(WIN_BASE)];
      SEL_SCAN:    rdata[0] = scan_en;
      SEL_SCAN_HW: rdata[0] = scan_hw;
      default: rdata = '0;
    endcase
  end

  logic unused_wdata;
  assign unused_wdata = ^{wdata[FREEZE_BIT-1:HI_LSB+CW], wdata[HI_LSB-1:CW]};

  p_shadow_stable_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !frame_wrap |=> $stable(scan_hw));

  p_shadow_copy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    frame_wrap |=> (scan_hw == $past(scan_en)));

  p_restart_unfreezes_r3: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> !frozen);

  p_single_window_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_we));

endmodule

// File: rtl/raster_timing_gen.sv
module raster_timing_gen
  import raster_pkg::*;
#(
  parameter int unsigned CW = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic [REG_AW-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic              hsync,
  output logic              vsync,
  output logic              hblank,
  output logic              vblank,
  output logic              hpix_en,
  output logic              vpix_en,
  output logic              hcmap_win,
  output logic              vcmap_win
);

  logic [CW-1:0]                  max_x, max_y;
  logic                           parked, frozen, restart;
  logic [CW-1:0]                  h_cnt, v_cnt, h_nxt, v_nxt;
  logic                           frame_wrap;
  logic                           cmp_load;
  logic [NUM_WIN-1:0]             win_we;
  logic [NUM_WIN-1:0]             win_bus;
  logic [NUM_WIN-1:0][DATA_W-1:0] win_rd;

  raster_regs #(.CW(CW)) regs_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .we         (reg_we),
    .addr       (reg_addr),
    .wdata      (reg_wdata),
    .rdata      (reg_rdata),
    .frame_wrap (frame_wrap),
    .h_cnt      (h_cnt),
    .v_cnt      (v_cnt),
    .win_rd     (win_rd),
    .max_x      (max_x),
    .max_y      (max_y),
    .parked     (parked),
    .frozen     (frozen),
    .restart    (restart),
    .win_we     (win_we)
  );

  raster_counter #(.CW(CW)) cnt_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .max_x      (max_x),
    .max_y      (max_y),
    .parked     (parked),
    .frozen     (frozen),
    .restart    (restart),
    .h_cnt      (h_cnt),
    .v_cnt      (v_cnt),
    .h_nxt      (h_nxt),
    .v_nxt      (v_nxt),
    .frame_wrap (frame_wrap)
  );

  // compare pairs move to the active set at a frame wrap, or at once when stopped
  assign cmp_load = frame_wrap || parked || frozen;

  for (genvar i = 0; i < NUM_WIN; i++) begin : g_win
    logic [CW-1:0] pos_sel;
    if (i % 2 == 0) begin : g_horiz
      assign pos_sel = h_nxt;
    end else begin : g_vert
      assign pos_sel = v_nxt;
    end
    timing_window #(.CW(CW)) win_i (
      .clk     (clk),
      .rst_n   (rst_n),
      .we      (win_we[i]),
      .wdata   (reg_wdata),
      .load    (cmp_load),
      .pos_nxt (pos_sel),
      .rd_val  (win_rd[i]),
      .win_out (win_bus[i])
    );
  end

  assign hsync     = win_bus[0];
  assign vsync     = win_bus[1];
  assign hblank    = win_bus[2];
  assign vblank    = win_bus[3];
  assign hpix_en   = win_bus[4];
  assign vpix_en   = win_bus[5];
  assign hcmap_win = win_bus[6];
  assign vcmap_win = win_bus[7];

  p_vert_steady_in_line_r4: assert property (@(posedge clk) disable iff (!rst_n)
    !cmp_load && !restart && (v_nxt == v_cnt) |=> $stable(vsync) && $stable(vblank)
      && $stable(vpix_en) && $stable(vcmap_win));

endmodule

// File: tb/raster_timing_gen_tb.sv
module raster_timing_gen_tb_top;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [3:0]  reg_addr = 4'd0;
  logic [31:0] reg_wdata = 32'd0;
  logic [31:0] reg_rdata;
  logic        hsync, vsync, hblank, vblank, hpix_en, vpix_en, hcmap_win, vcmap_win;

  always #4 clk = ~clk;

  raster_timing_gen #(.CW(12)) dut_i (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync(hsync), .vsync(vsync), .hblank(hblank), .vblank(vblank),
    .hpix_en(hpix_en), .vpix_en(vpix_en), .hcmap_win(hcmap_win), .vcmap_win(vcmap_win)
  );

  int n_checks = 0;
  int n_fail   = 0;

  // bench model of the block
  int mh, mv, mx, my;
  bit frz, sen, shw;
  int pon[8], poff[8], aon[8], aoff[8];

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=0x%08h expected=0x%08h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit exp_win(input int c, input int on, input int off);
    if (on == off) return 1'b0;
    if (on < off) return (c >= on) && (c < off);
    return !((c >= off) && (c < on));
  endfunction

  function automatic logic [31:0] model_read(input int a);
    logic [31:0] r = 32'd0;
    case (a)
      0: begin r[11:0] = 12'(mx); r[27:16] = 12'(my); end
      1: begin r[11:0] = 12'(mh); r[27:16] = 12'(mv); r[31] = frz; end
      2, 3, 4, 5, 6, 7, 8, 9: begin r[11:0] = 12'(pon[a-2]); r[27:16] = 12'(poff[a-2]); end
      10: r[0] = sen;
      11: r[0] = shw;
      default: r = 32'd0;
    endcase
    return r;
  endfunction

  function automatic string read_tag(input int a);
    if (a == 0) return "R2";
    if (a == 1) return frz ? "R3" : "R1";
    if (a >= 2 && a <= 9) return "R7";
    return "R8";
  endfunction

  task automatic check_now();
    logic [7:0] outs;
    outs = {vcmap_win, hcmap_win, vpix_en, hpix_en, vblank, hblank, vsync, hsync};
    for (int i = 0; i < 8; i++) begin
      bit e;
      string tag;
      e = exp_win((i % 2 == 0) ? mh : mv, aon[i], aoff[i]);
      if (aon[i] != pon[i] || aoff[i] != poff[i]) tag = "R7";
      else if (aon[i] == aoff[i]) tag = "R6";
      else if (aon[i] > aoff[i]) tag = "R5";
      else tag = "R4";
      chk(outs[i] == e, tag, 32'(outs[i]), 32'(e));
    end
    if (!reg_we && reg_addr <= 4'd11) begin
      logic [31:0] exp_r;
      exp_r = model_read(int'(reg_addr));
      chk(reg_rdata == exp_r, read_tag(int'(reg_addr)), reg_rdata, exp_r);
    end
  endtask

  task automatic model_edge(input bit w, input int a, input logic [31:0] d);
    bit running, rst_c, wrap, idle;
    idle    = (mx == 0 && my == 0) || frz;
    running = !idle;
    rst_c   = w && (a == 1) && !d[31];
    wrap    = running && !rst_c && (mh >= mx) && (mv >= my);
    if (wrap || idle)
      for (int i = 0; i < 8; i++) begin aon[i] = pon[i]; aoff[i] = poff[i]; end
    if (wrap) shw = sen;
    if (rst_c) begin mh = 0; mv = 0; end
    else if (running) begin
      if (mh >= mx) begin mh = 0; mv = (mv >= my) ? 0 : mv + 1; end
      else mh = mh + 1;
    end
    if (w) begin
      case (a)
        0: begin mx = int'(d[11:0]); my = int'(d[27:16]); end
        1: frz = d[31];
        2, 3, 4, 5, 6, 7, 8, 9: begin pon[a-2] = int'(d[11:0]); poff[a-2] = int'(d[27:16]); end
        10: sen = d[0];
        default: ;
      endcase
    end
  endtask

  task automatic tick(input bit w, input int a, input logic [31:0] d);
    check_now();
    reg_we = w; reg_addr = 4'(a); reg_wdata = d;
    @(posedge clk);
    model_edge(w, a, d);
    @(negedge clk);
  endtask

  function automatic logic [31:0] pair(input int on, input int off);
    return (32'(off) << 16) | 32'(on);
  endfunction

  initial begin
    mh = 0; mv = 0; mx = 0; my = 0; frz = 0; sen = 0; shw = 0;
    for (int i = 0; i < 8; i++) begin pon[i] = 4095; poff[i] = 4095; aon[i] = 4095; aoff[i] = 4095; end
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R9: reset state at the ports
    chk({hsync, vsync, hblank, vblank, hpix_en, vpix_en, hcmap_win, vcmap_win} == 8'd0,
        "R9", 32'({hsync, vsync, hblank, vblank, hpix_en, vpix_en, hcmap_win, vcmap_win}), 32'd0);
    chk(reg_rdata == 32'd0, "R9", reg_rdata, 32'd0);
    for (int a = 0; a < 12; a++) tick(1'b0, a, 32'd0);
    // R6: reset value of each compare pair
    tick(1'b0, 6, 32'd0);
    chk(reg_rdata == 32'h0FFF_0FFF, "R6", reg_rdata, 32'h0FFF_0FFF);

    // program windows while parked (R7 immediate load), wrap windows included (R5)
    tick(1'b1, 2, pair(2, 5));
    tick(1'b1, 3, pair(1, 2));
    tick(1'b1, 4, pair(8, 1));
    tick(1'b1, 5, pair(4, 1));
    tick(1'b1, 6, pair(7, 3));
    tick(1'b1, 7, pair(1, 4));
    tick(1'b1, 8, pair(8, 1));
    tick(1'b1, 9, pair(4, 1));
    for (int a = 2; a < 10; a++) tick(1'b0, a, 32'd0);
    repeat (4) tick(1'b0, 1, 32'd0);

    // R2/R1: start the raster and sweep several frames
    tick(1'b1, 0, pair(9, 5));
    repeat (130) tick(1'b0, 1, 32'd0);

    // R7: change compares mid-frame, including all ones on vertical pixel enable (R6)
    for (int k = 0; k < 80 && !(mh == 3 && mv == 2); k++) tick(1'b0, 1, 32'd0);
    tick(1'b1, 2, pair(6, 9));
    tick(1'b1, 7, 32'hFFFF_FFFF);
    repeat (130) tick(1'b0, 1, 32'd0);

    // R8: shadowed scan-out enable, polled across frame boundaries
    tick(1'b1, 10, 32'd1);
    repeat (70) tick(1'b0, 11, 32'd0);
    tick(1'b0, 10, 32'd0);
    tick(1'b1, 10, 32'd0);
    repeat (70) tick(1'b0, 11, 32'd0);

    // R3: freeze, compare change while frozen, then restart from origin
    tick(1'b1, 1, 32'h8000_0000);
    repeat (15) tick(1'b0, 1, 32'd0);
    tick(1'b1, 4, pair(3, 6));
    repeat (5) tick(1'b0, 1, 32'd0);
    tick(1'b1, 1, 32'd0);
    repeat (70) tick(1'b0, 1, 32'd0);

    // R1: shrink the totals while running
    tick(1'b1, 0, pair(3, 2));
    repeat (40) tick(1'b0, 1, 32'd0);
    tick(1'b0, 0, 32'd0);

    // R2: park, hold, then restart (R3)
    tick(1'b1, 0, 32'd0);
    repeat (10) tick(1'b0, 1, 32'd0);
    tick(1'b1, 1, 32'd0);
    repeat (5) tick(1'b0, 1, 32'd0);
    check_now();

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog R9 actual=0x%08h expected=0x%08h", 32'd1, 32'd0);
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

endmodule